// File: doc/BRIEF.md
# Merging Global Memory Block Controller

This block is the per-block state engine of one global memory unit in a shared-memory multiprocessor. It lets several processing elements (PEs) write copies of the same block at once and merges their changes word by word when the copies come back. For each block it keeps three pieces of state. The first is a count of how many PEs hold a copy; there is no list of which PEs they are. The second is a suspend bit. The third is a sticky mask with one bit per word, marking the words already taken from some writer.

The PEs issue eight kinds of request:

- a block fetch;
- a dirty flush carrying the full line;
- a clean replacement notice;
- a word read that bypasses caching;
- a word write that bypasses caching;
- a lock;
- an unlock;
- a test-and-set.

A flush that is not the sole copy is merged over `WORDS` clock cycles, one word per clock. The `busy` output is high during this time and no new request is accepted. A request that finds the block suspended is not answered. Instead, it is pushed to an external suspend queue. When a block's count drains or it is unlocked, a reinitialize event tells that queue the block can be served again.

Top module: `merge_block_ctrl`

## Requirements
- R1: After reset, every block has count 0, suspend 0, a clear mask and all-zero data, and all output strobes and `busy` are low.
- R2: A fetch (`reqOp`=0) to a block whose suspend bit is 0 increments its count, saturating at all ones. One cycle after acceptance it pulses `rspValid` with the block on `rspLine`, where word w occupies bits [w*DW +: DW].
- R3: A fetch to a suspended block returns no response. Instead, it pulses `qPushValid` one cycle later with the requester, the block, `tsNow` as stamp and `qPushLock`=0.
- R4: A flush (`reqOp`=1) that finds count 1 and suspend 0 stores the whole line, sets the count to 0 and completes in one cycle without `busy`.
- R5: Any other flush visits each word whose mask bit is 0. Where the incoming word differs from the stored one, it overwrites the stored word and sets the mask bit. Words with mask bit 1 keep their stored value.
- R6: After the merge, the count is decremented and suspend is set. If the count reaches 0, a reinitialize happens and `reinitValid` pulses with the block in the cycle `busy` falls.
- R7: A replacement notice (`reqOp`=2) decrements the count without changing data. Reaching 0 triggers a reinitialize.
- R8: A reinitialize clears the block's mask and suspend bit, so a following fetch is served normally.
- R9: A lock (`reqOp`=5) with suspend 0 sets suspend and answers `rspOld`=0. With suspend 1, it is pushed to the queue with `qPushLock`=1 and stamp 0.
- R10: A test-and-set (`reqOp`=7) always sets suspend and answers its previous value on `rspOld`. An unlock (`reqOp`=6) performs a reinitialize.
- R11: A bypass read (`reqOp`=3) answers the addressed word on `rspWord`. A bypass write (`reqOp`=4) stores `reqWdata` at the addressed word. Neither reads nor changes count, suspend or mask.
- R12: A merging flush holds `busy` high for exactly `WORDS` cycles after acceptance, and no response or queue push occurs while it runs.
- R13: A decrement when the count is already 0 leaves the count at 0, pulses `errUnderflow` and performs no reinitialize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; accepted when `busy` is low |
| reqOp | input | 3 | Operation code (0 fetch, 1 flush, 2 replace, 3 bypass read, 4 bypass write, 5 lock, 6 unlock, 7 test-and-set) |
| reqPe | input | $clog2(NUM_PE) | Requesting PE |
| reqBlock | input | $clog2(BLOCKS) | Target block |
| reqWord | input | $clog2(WORDS) | Word index for bypass accesses |
| reqWdata | input | DW | Bypass write data |
| reqLine | input | WORDS*DW | Flushed line |
| tsNow | input | TS_W | Current timestamp |
| busy | output | 1 | Merge in progress |
| rspValid | output | 1 | Response strobe |
| rspOld | output | 1 | Previous suspend value for lock and test-and-set |
| rspWord | output | DW | Bypass read data |
| rspLine | output | WORDS*DW | Fetched line |
| qPushValid | output | 1 | Suspend queue push strobe |
| qPushPe | output | $clog2(NUM_PE) | Queued requester |
| qPushBlock | output | $clog2(BLOCKS) | Queued block |
| qPushStamp | output | TS_W | Timestamp, 0 for lock entries |
| qPushLock | output | 1 | Entry is a lock request |
| reinitValid | output | 1 | Reinitialize event strobe |
| reinitBlock | output | $clog2(BLOCKS) | Block reinitialized |
| errUnderflow | output | 1 | Decrement at zero count |

## Verification
The bench builds the block with four PEs, four blocks, four 16-bit words per block and a 16-bit stamp. With those values, the 3-bit count reaches saturation within a short random run, and a full merge takes four busy cycles. Two PEs can share a block and write disjoint words, which exercises the sticky mask. A third PE can then meet the suspended block and be queued. Directed cases come first: reset state, a two-writer merge whose second flush carries a stale copy of the first writer's word, the exclusive flush, lock contention and underflow. A seeded random mix of all eight operations follows, checked against a bench model of count, suspend, mask and data.

// File: rtl/merge_pkg.sv
package merge_pkg;

  typedef enum logic [2:0] {
    OP_FETCH   = 3'd0,
    OP_FLUSH   = 3'd1,
    OP_REPLACE = 3'd2,
    OP_BYP_RD  = 3'd3,
    OP_BYP_WR  = 3'd4,
    OP_LOCK    = 3'd5,
    OP_UNLOCK  = 3'd6,
    OP_TAS     = 3'd7
  } op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_MERGE = 1'b1
  } ctl_state_e;

  // Strobes from control to datapath, all valid for one clock.
  typedef struct packed {
    logic lineWr;   // store whole incoming line
    logic lineCap;  // capture incoming line for a merge
    logic mergeEn;  // merge one word at mergeIdx
    logic maskClr;  // clear the block's modified mask
    logic wordWr;   // bypass word write
    logic lineRd;   // register block onto rspLine
    logic wordRd;   // register word onto rspWord
  } dp_ctl_t;

endpackage

// File: rtl/merge_datapath.sv
module merge_datapath
  import merge_pkg::*;
#(
  parameter int BLOCKS = 4,
  parameter int WORDS  = 4,
  parameter int DW     = 16,
  localparam int BW    = $clog2(BLOCKS),
  localparam int WW    = $clog2(WORDS),
  localparam int LW    = WORDS * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  dp_ctl_t       ctl,
  input  logic [BW-1:0] blk,
  input  logic [WW-1:0] word,
  input  logic [WW-1:0] mergeIdx,
  input  logic [LW-1:0] inLine,
  input  logic [DW-1:0] inWord,
  output logic [LW-1:0] rspLine,
  output logic [DW-1:0] rspWord
);

  logic [DW-1:0]    store   [BLOCKS][WORDS];
  logic [WORDS-1:0] maskArr [BLOCKS];
  logic [DW-1:0]    holdLine[WORDS];

  logic [DW-1:0] mergeNew;
  logic [DW-1:0] mergeOld;
  logic          mergeTake;

  always_comb begin
    mergeNew  = holdLine[mergeIdx];
    mergeOld  = store[blk][mergeIdx];
    mergeTake = ctl.mergeEn && !maskArr[blk][mergeIdx] && (mergeNew != mergeOld);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < BLOCKS; b++) begin
        maskArr[b] <= '0;
        for (int w = 0; w < WORDS; w++) store[b][w] <= '0;
      end
      for (int w = 0; w < WORDS; w++) holdLine[w] <= '0;
      rspLine <= '0;
      rspWord <= '0;
    end else begin
      if (ctl.lineCap) begin
        for (int w = 0; w < WORDS; w++) holdLine[w] <= inLine[w*DW +: DW];
      end
      if (ctl.lineWr) begin
        for (int w = 0; w < WORDS; w++) store[blk][w] <= inLine[w*DW +: DW];
      end
      if (ctl.wordWr) store[blk][word] <= inWord;
      if (mergeTake) begin
        store[blk][mergeIdx]   <= mergeNew;
        maskArr[blk][mergeIdx] <= 1'b1;
      end
      if (ctl.maskClr) maskArr[blk] <= '0;
      if (ctl.lineRd) begin
        for (int w = 0; w < WORDS; w++) rspLine[w*DW +: DW] <= store[blk][w];
      end
      if (ctl.wordRd) rspWord <= store[blk][word];
    end
  end

endmodule

// File: rtl/merge_ctrl.sv
module merge_ctrl
  import merge_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int BLOCKS = 4,
  parameter int WORDS  = 4,
  parameter int TS_W   = 16,
  localparam int PEW   = $clog2(NUM_PE),
  localparam int BW    = $clog2(BLOCKS),
  localparam int WW    = $clog2(WORDS),
  localparam int CW    = $clog2(NUM_PE + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      reqOp,
  input  logic [PEW-1:0]  reqPe,
  input  logic [BW-1:0]   reqBlock,
  input  logic [TS_W-1:0] tsNow,
  output dp_ctl_t         dpCtl,
  output logic [BW-1:0]   dpBlk,
  output logic [WW-1:0]   mergeIdx,
  output logic            busy,
  output logic            rspValid,
  output logic            rspOld,
  output logic            qPushValid,
  output logic [PEW-1:0]  qPushPe,
  output logic [BW-1:0]   qPushBlock,
  output logic [TS_W-1:0] qPushStamp,
  output logic            qPushLock,
  output logic            reinitValid,
  output logic [BW-1:0]   reinitBlock,
  output logic            errUnderflow
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [WW-1:0] LAST_W  = WW'(WORDS - 1);

  ctl_state_e    state;
  logic [BW-1:0] curBlk;
  logic [CW-1:0] cnt  [BLOCKS];
  logic          susp [BLOCKS];

  op_e           op;
  logic          accept;
  logic [CW-1:0] reqCnt;
  logic          reqSusp;
  logic [CW-1:0] mrgCnt;
  logic          lastWord;
  logic          exclusive;

  always_comb begin
    op        = op_e'(reqOp);
    busy      = (state == ST_MERGE);
    accept    = reqValid && !busy;
    reqCnt    = cnt[reqBlock];
    reqSusp   = susp[reqBlock];
    mrgCnt    = cnt[curBlk];
    lastWord  = (mergeIdx == LAST_W);
    exclusive = (reqCnt == CNT_ONE) && !reqSusp;
    dpBlk     = busy ? curBlk : reqBlock;
    dpCtl     = '0;
    if (busy) begin
      dpCtl.mergeEn = 1'b1;
      if (lastWord && mrgCnt == CNT_ONE) dpCtl.maskClr = 1'b1;
    end else if (accept) begin
      unique case (op)
        OP_FETCH:   dpCtl.lineRd = !reqSusp;
        OP_FLUSH: begin
          dpCtl.lineWr  = exclusive;
          dpCtl.lineCap = !exclusive;
        end
        OP_REPLACE: dpCtl.maskClr = (reqCnt == CNT_ONE);
        OP_BYP_RD:  dpCtl.wordRd  = 1'b1;
        OP_BYP_WR:  dpCtl.wordWr  = 1'b1;
        OP_UNLOCK:  dpCtl.maskClr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      curBlk       <= '0;
      mergeIdx     <= '0;
      rspValid     <= 1'b0;
      rspOld       <= 1'b0;
      qPushValid   <= 1'b0;
      qPushPe      <= '0;
      qPushBlock   <= '0;
      qPushStamp   <= '0;
      qPushLock    <= 1'b0;
      reinitValid  <= 1'b0;
      reinitBlock  <= '0;
      errUnderflow <= 1'b0;
      for (int b = 0; b < BLOCKS; b++) begin
        cnt[b]  <= '0;
        susp[b] <= 1'b0;
      end
    end else begin
      rspValid     <= 1'b0;
      qPushValid   <= 1'b0;
      reinitValid  <= 1'b0;
      errUnderflow <= 1'b0;
      if (busy) begin
        mergeIdx <= mergeIdx + WW'(1);
        if (lastWord) begin
          state    <= ST_IDLE;
          mergeIdx <= '0;
          if (mrgCnt == '0) begin
            errUnderflow <= 1'b1;
            susp[curBlk] <= 1'b1;
          end else if (mrgCnt == CNT_ONE) begin
            cnt[curBlk]  <= '0;
            susp[curBlk] <= 1'b0;
            reinitValid  <= 1'b1;
            reinitBlock  <= curBlk;
          end else begin
            cnt[curBlk]  <= mrgCnt - CNT_ONE;
            susp[curBlk] <= 1'b1;
          end
        end
      end else if (accept) begin
        unique case (op)
          OP_FETCH: begin
            if (reqSusp) begin
              qPushValid <= 1'b1;
              qPushPe    <= reqPe;
              qPushBlock <= reqBlock;
              qPushStamp <= tsNow;
              qPushLock  <= 1'b0;
            end else begin
              if (reqCnt != '1) cnt[reqBlock] <= reqCnt + CNT_ONE;
              rspValid <= 1'b1;
            end
          end
          OP_FLUSH: begin
            if (exclusive) begin
              cnt[reqBlock] <= '0;
            end else begin
              state    <= ST_MERGE;
              curBlk   <= reqBlock;
              mergeIdx <= '0;
            end
          end
          OP_REPLACE: begin
            if (reqCnt == '0) begin
              errUnderflow <= 1'b1;
            end else begin
              cnt[reqBlock] <= reqCnt - CNT_ONE;
              if (reqCnt == CNT_ONE) begin
                susp[reqBlock] <= 1'b0;
                reinitValid    <= 1'b1;
                reinitBlock    <= reqBlock;
              end
            end
          end
          OP_BYP_RD: rspValid <= 1'b1;
          OP_BYP_WR: ;
          OP_LOCK: begin
            if (reqSusp) begin
              qPushValid <= 1'b1;
              qPushPe    <= reqPe;
              qPushBlock <= reqBlock;
              qPushStamp <= '0;
              qPushLock  <= 1'b1;
            end else begin
              susp[reqBlock] <= 1'b1;
              rspValid       <= 1'b1;
              rspOld         <= 1'b0;
            end
          end
          OP_UNLOCK: begin
            susp[reqBlock] <= 1'b0;
            reinitValid    <= 1'b1;
            reinitBlock    <= reqBlock;
          end
          OP_TAS: begin
            susp[reqBlock] <= 1'b1;
            rspValid       <= 1'b1;
            rspOld         <= reqSusp;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/merge_block_ctrl.sv
module merge_block_ctrl
  import merge_pkg::*;
#(
  parameter int NUM_PE = 4,
  parameter int BLOCKS = 4,
  parameter int WORDS  = 4,
  parameter int DW     = 16,
  parameter int TS_W   = 16,
  localparam int PEW   = $clog2(NUM_PE),
  localparam int BW    = $clog2(BLOCKS),
  localparam int WW    = $clog2(WORDS),
  localparam int LW    = WORDS * DW
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [2:0]      reqOp,
  input  logic [PEW-1:0]  reqPe,
  input  logic [BW-1:0]   reqBlock,
  input  logic [WW-1:0]   reqWord,
  input  logic [DW-1:0]   reqWdata,
  input  logic [LW-1:0]   reqLine,
  input  logic [TS_W-1:0] tsNow,
  output logic            busy,
  output logic            rspValid,
  output logic            rspOld,
  output logic [DW-1:0]   rspWord,
  output logic [LW-1:0]   rspLine,
  output logic            qPushValid,
  output logic [PEW-1:0]  qPushPe,
  output logic [BW-1:0]   qPushBlock,
  output logic [TS_W-1:0] qPushStamp,
  output logic            qPushLock,
  output logic            reinitValid,
  output logic [BW-1:0]   reinitBlock,
  output logic            errUnderflow
);

  dp_ctl_t       dpCtl;
  logic [BW-1:0] dpBlk;
  logic [WW-1:0] mergeIdx;

  merge_ctrl #(
    .NUM_PE(NUM_PE), .BLOCKS(BLOCKS), .WORDS(WORDS), .TS_W(TS_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqPe(reqPe), .reqBlock(reqBlock), .tsNow(tsNow),
    .dpCtl(dpCtl), .dpBlk(dpBlk), .mergeIdx(mergeIdx), .busy(busy),
    .rspValid(rspValid), .rspOld(rspOld), .qPushValid(qPushValid),
    .qPushPe(qPushPe), .qPushBlock(qPushBlock), .qPushStamp(qPushStamp),
    .qPushLock(qPushLock), .reinitValid(reinitValid),
    .reinitBlock(reinitBlock), .errUnderflow(errUnderflow)
  );

  merge_datapath #(
    .BLOCKS(BLOCKS), .WORDS(WORDS), .DW(DW)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(dpCtl), .blk(dpBlk), .word(reqWord),
    .mergeIdx(mergeIdx), .inLine(reqLine), .inWord(reqWdata),
    .rspLine(rspLine), .rspWord(rspWord)
  );

endmodule

// File: rtl/merge_block_ctrl_chk.sv
module merge_block_ctrl_chk #(
  parameter int WORDS = 4,
  parameter int TS_W  = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            rspValid,
  input logic            qPushValid,
  input logic            qPushLock,
  input logic [TS_W-1:0] qPushStamp,
  input logic            reinitValid,
  input logic            errUnderflow
);

  int unsigned busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyRun <= 0;
    else       busyRun <= busy ? busyRun + 1 : 0;
  end

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < WORDS)); // R12
  AST_QUIET_IN_MERGE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (!rspValid && !qPushValid)); // R12
  AST_QUEUE_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    qPushValid |-> !rspValid); // R3
  AST_LOCK_STAMP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (qPushValid && qPushLock) |-> (qPushStamp == '0)); // R9
  AST_REINIT_NO_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    reinitValid |-> !qPushValid); // R8
  AST_UNDERFLOW_NO_REINIT: assert property (@(posedge clk) disable iff (!rstN)
    errUnderflow |-> !reinitValid); // R13

endmodule

bind merge_block_ctrl merge_block_ctrl_chk #(.WORDS(WORDS), .TS_W(TS_W)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .rspValid(rspValid),
  .qPushValid(qPushValid), .qPushLock(qPushLock), .qPushStamp(qPushStamp),
  .reinitValid(reinitValid), .errUnderflow(errUnderflow)
);

// File: tb/merge_block_ctrl_tb_top.sv
module merge_block_ctrl_tb_top;

  localparam int NPE = 4;
  localparam int NB  = 4;
  localparam int NW  = 4;
  localparam int DW  = 16;
  localparam int TSW = 16;
  localparam int CMAX = 7;

  localparam int FETCH = 0, FLUSH = 1, REPL = 2, BRD = 3, BWR = 4,
                 LOCK = 5, UNLK = 6, TAS = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic [1:0] reqPe = '0;
  logic [1:0] reqBlock = '0;
  logic [1:0] reqWord = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [NW*DW-1:0] reqLine = '0;
  logic [TSW-1:0] tsNow = '0;
  logic busy, rspValid, rspOld, qPushValid, qPushLock, reinitValid, errUnderflow;
  logic [DW-1:0] rspWord;
  logic [NW*DW-1:0] rspLine;
  logic [1:0] qPushPe, qPushBlock, reinitBlock;
  logic [TSW-1:0] qPushStamp;

  always #5 clk = ~clk;

  merge_block_ctrl #(.NUM_PE(NPE), .BLOCKS(NB), .WORDS(NW), .DW(DW), .TS_W(TSW)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqPe(reqPe),
    .reqBlock(reqBlock), .reqWord(reqWord), .reqWdata(reqWdata), .reqLine(reqLine),
    .tsNow(tsNow), .busy(busy), .rspValid(rspValid), .rspOld(rspOld),
    .rspWord(rspWord), .rspLine(rspLine), .qPushValid(qPushValid),
    .qPushPe(qPushPe), .qPushBlock(qPushBlock), .qPushStamp(qPushStamp),
    .qPushLock(qPushLock), .reinitValid(reinitValid), .reinitBlock(reinitBlock),
    .errUnderflow(errUnderflow)
  );

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [DW-1:0] mData [NB][NW];
  logic [NW-1:0] mMask [NB];
  int            mCnt  [NB];
  bit            mSusp [NB];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  function automatic logic [63:0] packBlk(input int b);
    logic [63:0] v;
    for (int w = 0; w < NW; w++) v[w*DW +: DW] = mData[b][w];
    return v;
  endfunction

  task automatic runOp(input int op, input int pe, input int blk, input int wd,
                       input logic [DW-1:0] wv, input logic [63:0] ln);
    bit expRsp = 0, expOld = 0, expQ = 0, expQLock = 0, expReinit = 0, expErr = 0, merging = 0;
    logic [63:0] expLine = '0;
    logic [DW-1:0] expWord = '0;
    logic [TSW-1:0] stamp;
    string tag;
    int n;
    stamp = TSW'($urandom);
    tag = "R11";
    case (op)
      FETCH: begin
        if (mSusp[blk]) begin expQ = 1; tag = "R3"; end
        else begin
          if (mCnt[blk] < CMAX) mCnt[blk]++;
          expRsp = 1; expLine = packBlk(blk); tag = "R2";
        end
      end
      FLUSH: begin
        if (mCnt[blk] == 1 && !mSusp[blk]) begin
          for (int w = 0; w < NW; w++) mData[blk][w] = ln[w*DW +: DW];
          mCnt[blk] = 0; tag = "R4";
        end else begin
          merging = 1; tag = "R6";
          for (int w = 0; w < NW; w++)
            if (!mMask[blk][w] && ln[w*DW +: DW] != mData[blk][w]) begin
              mMask[blk][w] = 1'b1; mData[blk][w] = ln[w*DW +: DW];
            end
          if (mCnt[blk] == 0) begin expErr = 1; mSusp[blk] = 1; end
          else begin
            mCnt[blk]--; mSusp[blk] = 1;
            if (mCnt[blk] == 0) begin mMask[blk] = '0; mSusp[blk] = 0; expReinit = 1; end
          end
        end
      end
      REPL: begin
        tag = "R7";
        if (mCnt[blk] == 0) expErr = 1;
        else begin
          mCnt[blk]--;
          if (mCnt[blk] == 0) begin mMask[blk] = '0; mSusp[blk] = 0; expReinit = 1; end
        end
      end
      BRD: begin expRsp = 1; expWord = mData[blk][wd]; end
      BWR: mData[blk][wd] = wv;
      LOCK: begin
        tag = "R9";
        if (mSusp[blk]) begin expQ = 1; expQLock = 1; end
        else begin mSusp[blk] = 1; expRsp = 1; expOld = 0; end
      end
      UNLK: begin tag = "R10"; mMask[blk] = '0; mSusp[blk] = 0; expReinit = 1; end
      default: begin tag = "R10"; expRsp = 1; expOld = mSusp[blk]; mSusp[blk] = 1; end
    endcase

    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'(op); reqPe = 2'(pe); reqBlock = 2'(blk);
    reqWord = 2'(wd); reqWdata = wv; reqLine = ln; tsNow = stamp;
    @(negedge clk);
    reqValid = 1'b0;
    if (merging) begin
      n = 0;
      while (busy && n < 64) begin
        n++;
        check("R12 no response while merging", {62'b0, rspValid, qPushValid}, 64'd0);
        @(negedge clk);
      end
      check("R12 busy cycles", 64'(n), 64'(NW));
    end else begin
      check({tag, " busy"}, {63'b0, busy}, 64'd0);
    end
    check({tag, " rspValid"}, {63'b0, rspValid}, {63'b0, expRsp});
    if (expRsp && (op == LOCK || op == TAS)) check({tag, " rspOld"}, {63'b0, rspOld}, {63'b0, expOld});
    if (expRsp && op == FETCH) check("R2 rspLine", rspLine, expLine);
    if (expRsp && op == BRD) check("R11 rspWord", {48'b0, rspWord}, {48'b0, expWord});
    check({tag, " qPushValid"}, {63'b0, qPushValid}, {63'b0, expQ});
    if (expQ) begin
      check({tag, " queue entry"}, {qPushStamp, 12'b0, qPushPe, qPushBlock, 3'b0, qPushLock},
            {(expQLock ? 16'd0 : stamp), 12'b0, 2'(pe), 2'(blk), 3'b0, expQLock});
    end
    check(expReinit ? {tag, " R8 reinitValid"} : {tag, " reinitValid"},
          {63'b0, reinitValid}, {63'b0, expReinit});
    if (expReinit) check("R8 reinitBlock", {62'b0, reinitBlock}, 64'(blk));
    check("R13 errUnderflow", {63'b0, errUnderflow}, {63'b0, expErr});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nRun++; nFail++;
    $display("FAIL watchdog act=timeout exp=finish");
    finishRun();
  end

  initial begin
    logic [63:0] ln;
    void'($urandom(32'd20240611));
    for (int b = 0; b < NB; b++) begin
      mMask[b] = '0; mCnt[b] = 0; mSusp[b] = 0;
      for (int w = 0; w < NW; w++) mData[b][w] = '0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check("R1 reset strobes", {58'b0, busy, rspValid, qPushValid, reinitValid, errUnderflow, rspOld}, 64'd0);
    runOp(REPL, 0, 3, 0, 0, 0);          // R1 count zero -> underflow
    runOp(TAS, 0, 2, 0, 0, 0);           // R1 suspend zero
    runOp(FETCH, 0, 0, 0, 0, 0);         // R1 data zero
    check("R1 reset data", rspLine, 64'd0);
    runOp(REPL, 0, 0, 0, 0, 0);

    // false sharing: two writers, disjoint words
    runOp(FETCH, 0, 1, 0, 0, 0);
    runOp(FETCH, 1, 1, 0, 0, 0);
    runOp(FLUSH, 0, 1, 0, 0, 64'h0000_0000_0000_1111);
    runOp(FETCH, 2, 1, 0, 0, 0);         // R3 suspended fetch
    runOp(FLUSH, 1, 1, 0, 0, 64'h0000_0000_2222_0000);
    runOp(FETCH, 2, 1, 0, 0, 0);
    check("R5 merged line keeps masked word", rspLine, 64'h0000_0000_2222_1111);
    check("R8 fetch served after reinit", {63'b0, rspValid}, 64'd1);
    runOp(REPL, 2, 1, 0, 0, 0);

    // exclusive flush
    runOp(FETCH, 3, 3, 0, 0, 0);
    runOp(FLUSH, 3, 3, 0, 0, 64'hdead_beef_0123_4567);
    runOp(FETCH, 3, 3, 0, 0, 0);
    check("R4 exclusive line stored", rspLine, 64'hdead_beef_0123_4567);

    // locks
    runOp(UNLK, 0, 2, 0, 0, 0);
    runOp(LOCK, 1, 2, 0, 0, 0);
    runOp(LOCK, 2, 2, 0, 0, 0);
    runOp(TAS, 3, 2, 0, 0, 0);
    runOp(UNLK, 1, 2, 0, 0, 0);

    // bypass
    runOp(BWR, 0, 0, 2, 16'h5a5a, 0);
    runOp(BRD, 1, 0, 2, 0, 0);
    runOp(FETCH, 1, 0, 0, 0, 0);
    check("R11 bypass write visible in line", rspLine, 64'h0000_5a5a_0000_0000);

    // underflow merge: flush with count 0
    runOp(REPL, 1, 0, 0, 0, 0);
    runOp(FLUSH, 1, 0, 0, 0, 64'h1);
    runOp(UNLK, 1, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int op, b;
      op = $urandom_range(0, 7);
      b  = $urandom_range(0, NB - 1);
      ln = packBlk(b);
      for (int w = 0; w < NW; w++)
        if ($urandom_range(0, 1) == 1) ln[w*DW +: DW] = DW'($urandom);
      runOp(op, $urandom_range(0, NPE - 1), b, $urandom_range(0, NW - 1), DW'($urandom), ln);
    end
    finishRun();
  end

endmodule